// File: doc/BRIEF.md
# Dual-Timing External Bus Sequencer

This block turns the per-cycle memory requests of an 8-bit processor core into external bus signals: a 13-bit address, an active-low chip enable, separate active-low read and write strobes, a function-select line, and the output enable and data of an 8-bit bidirectional data bus. Every machine cycle lasts two clocks. The first clock is for setup and bus turnaround. The second clock carries the data transfer, and the strobes are asserted in it. The block tells the core which clock samples its request, and it returns the data read from external memory.

A mode input is sampled only while reset is held. It selects between two timings. In normal mode, address, function select and read strobe change at the start of the transfer clock, so standard memories can be wired directly to the bus. In debug mode, address, function select and read line change one clock earlier, so an external latch and tracing logic can capture them. In this mode the read line shows read/write direction for the whole of every requested cycle, whether the target is internal or external, and accesses that fall in the on-chip RAM window are sent to external space. Chip enable and write strobe have the same timing in both modes.

The core decodes each request as internal or external. The block adds the RAM remap and a programmable unused window in the low I/O page. Chip enable never asserts for an address in that window.

Top module: `dualtime_bus_if`

## Requirements
- R1: While `rst` is high, all outputs hold their idle values: address 0, function select 0, `take` 0, enable and strobes high, bus not driven, `db_out` 0, `rd_vld` 0. `mode_dbg` is captured only while `rst` is high, and later changes have no effect until the next reset.
- R2: In normal mode, `bus_addr` and `bus_fs` update at the start of the transfer clock. `bus_addr` takes the request address, or holds its value for an idle cycle. `bus_fs` is the fetch flag of a valid request. Both hold through the following setup clock.
- R3: In debug mode, `bus_addr` and `bus_fs` update at the start of the setup clock, one clock before the transfer, and hold through the transfer clock.
- R4: `bus_ce_n` is low only in the transfer clock of an external access. An access is external when the request is valid, the address is outside the unused window (0x020 to 0x02F by default), and the core marks it external or the RAM remap of R8 applies.
- R5: `bus_we_n` is low only in the transfer clock of an external write. Its timing is the same in both modes.
- R6: In normal mode, `bus_rd_n` is low only in the transfer clock of an external read.
- R7: In debug mode, `bus_rd_n` is low for both clocks of every valid read cycle, including internal and unused-window reads. It is high for writes and idle cycles.
- R8: In debug mode, a request marked internal whose address is inside the RAM window (0x040 to 0x0FF by default) is handled as external. In normal mode, the same request stays internal.
- R9: `db_oe` is 0 in every setup clock and in the transfer clock of an external read. It is 1 in all other transfer clocks, including idle cycles.
- R10: In the transfer clock, `db_out` carries the write data of a valid write, or `int_rdata` (sampled at the end of the setup clock) for an internal read. It holds its value otherwise.
- R11: At the end of an external read, `db_in` is captured into `rd_data`, and `rd_vld` is high for exactly the following clock.
- R12: `take` is high in the transfer clock. The request inputs are sampled at the end of that clock and are carried out in the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dbg | input | 1 | Timing mode, 1 = debug, sampled during reset |
| take | output | 1 | High in the clock whose end samples the request |
| req_vld | input | 1 | Request present for the next machine cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Fetch attribute, shown on `bus_fs` |
| req_int | input | 1 | Core decodes the address as internal |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write data |
| int_rdata | input | 8 | Internal read data, sampled at the end of the setup clock |
| bus_addr | output | 13 | External address |
| bus_fs | output | 1 | Function select |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe (normal) or R/W status (debug) |
| db_oe | output | 1 | 1 = block drives the data bus |
| db_out | output | 8 | Data driven on the bus |
| db_in | input | 8 | Data received from the bus |
| rd_data | output | 8 | Last external read data |
| rd_vld | output | 1 | One-clock pulse when `rd_data` is new |

## Verification
The sweep crosses both modes with addresses on each edge of the unused window and of the RAM window, both internal and external decodes, and both directions. It checks every output in both clocks of each machine cycle. A design that skipped the unused-window gate would assert chip enable on reserved I/O addresses. A design that applied the RAM remap in normal mode would read external memory for on-chip RAM. A one-clock slip in the debug timing would show up as an address that changes inside the transfer clock. The mode input is toggled after reset to catch a design that samples it live, and idle cycles confirm that the address holds and that the bus is driven while the read line stays high.

// File: rtl/bus_if_pkg.sv
package bus_if_pkg;
  typedef enum logic {PH_SETUP = 1'b0, PH_XFER = 1'b1} phase_e;

  typedef struct packed {
    logic vld;
    logic wr;
    logic fetch;
    logic intl;
  } req_attr_t;
endpackage

// File: rtl/bus_phase.sv
module bus_phase
  import bus_if_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   mode_in,
  output phase_e ph,
  output logic   dbg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_SETUP;
      dbg <= mode_in;
    end else begin
      ph  <= (ph == PH_SETUP) ? PH_XFER : PH_SETUP;
    end
  end
endmodule

// File: rtl/bus_decode.sv
module bus_decode
  import bus_if_pkg::*;
#(
  parameter int AW     = 13,
  parameter int RAM_LO = 'h040,
  parameter int RAM_HI = 'h0FF,
  parameter int GAP_LO = 'h020,
  parameter int GAP_HI = 'h02F
) (
  input  req_attr_t       attr,
  input  logic [AW-1:0]   addr,
  input  logic            dbg,
  output logic            ext,
  output logic            ext_rd,
  output logic            ext_wr,
  output logic            int_rd
);
  localparam logic [AW-1:0] RLO = AW'(RAM_LO);
  localparam logic [AW-1:0] RHI = AW'(RAM_HI);
  localparam logic [AW-1:0] GLO = AW'(GAP_LO);
  localparam logic [AW-1:0] GHI = AW'(GAP_HI);

  logic in_ram, in_gap;

  always_comb begin
    in_ram = (addr >= RLO) && (addr <= RHI);
    in_gap = (addr >= GLO) && (addr <= GHI);
    ext    = attr.vld && !in_gap && (!attr.intl || (dbg && in_ram));
    ext_rd = ext && !attr.wr;
    ext_wr = ext && attr.wr;
    int_rd = attr.vld && !attr.wr && !ext;
  end
endmodule

// File: rtl/bus_strobes.sv
module bus_strobes
  import bus_if_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        ph,
  input  logic          dbg,
  input  req_attr_t     nxt_attr,
  input  logic [AW-1:0] nxt_addr,
  input  req_attr_t     cur_attr,
  input  logic [AW-1:0] cur_addr,
  input  logic          ext,
  input  logic          ext_rd,
  input  logic          ext_wr,
  output logic [AW-1:0] addr_o,
  output logic          fs_o,
  output logic          ce_n,
  output logic          we_n,
  output logic          rd_n,
  output logic          oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      fs_o   <= 1'b0;
      ce_n   <= 1'b1;
      we_n   <= 1'b1;
      rd_n   <= 1'b1;
      oe     <= 1'b0;
    end else if (ph == PH_XFER) begin
      // entering setup clock of the next machine cycle
      ce_n <= 1'b1;
      we_n <= 1'b1;
      oe   <= 1'b0;
      if (dbg) begin
        if (nxt_attr.vld) addr_o <= nxt_addr;
        fs_o <= nxt_attr.vld && nxt_attr.fetch;
        rd_n <= !(nxt_attr.vld && !nxt_attr.wr);
      end else begin
        rd_n <= 1'b1;
      end
    end else begin
      // entering transfer clock
      ce_n <= !ext;
      we_n <= !ext_wr;
      oe   <= !ext_rd;
      if (!dbg) begin
        if (cur_attr.vld) addr_o <= cur_addr;
        fs_o <= cur_attr.vld && cur_attr.fetch;
        rd_n <= !ext_rd;
      end
    end
  end
endmodule

// File: rtl/bus_data.sv
module bus_data
  import bus_if_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        ph,
  input  req_attr_t     nxt_attr,
  input  req_attr_t     cur_attr,
  input  logic [DW-1:0] nxt_wdata,
  input  logic [DW-1:0] int_rdata,
  input  logic [DW-1:0] db_in,
  input  logic          ext_rd,
  input  logic          int_rd,
  output logic [DW-1:0] db_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  logic [DW-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q    <= '0;
      db_out  <= '0;
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else if (ph == PH_XFER) begin
      if (nxt_attr.vld && nxt_attr.wr) wd_q <= nxt_wdata;
      rd_vld <= ext_rd;
      if (ext_rd) rd_data <= db_in;
    end else begin
      rd_vld <= 1'b0;
      if (cur_attr.vld && cur_attr.wr) db_out <= wd_q;
      else if (int_rd)                 db_out <= int_rdata;
    end
  end
endmodule

// File: rtl/dualtime_bus_if.sv
module dualtime_bus_if
  import bus_if_pkg::*;
#(
  parameter int AW     = 13,
  parameter int DW     = 8,
  parameter int RAM_LO = 'h040,
  parameter int RAM_HI = 'h0FF,
  parameter int GAP_LO = 'h020,
  parameter int GAP_HI = 'h02F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_dbg,
  output logic          take,
  input  logic          req_vld,
  input  logic          req_wr,
  input  logic          req_fetch,
  input  logic          req_int,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] int_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_fs,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_rd_n,
  output logic          db_oe,
  output logic [DW-1:0] db_out,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  phase_e        ph;
  logic          dbg_q;
  req_attr_t     nxt_attr, cur_attr;
  logic [AW-1:0] cur_addr;
  logic          ext, ext_rd, ext_wr, int_rd;

  assign nxt_attr = '{vld: req_vld, wr: req_wr, fetch: req_fetch, intl: req_int};
  assign take     = (ph == PH_XFER);

  bus_phase u_phase (
    .clk(clk), .rst(rst), .mode_in(mode_dbg), .ph(ph), .dbg(dbg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_attr <= '0;
      cur_addr <= '0;
    end else if (ph == PH_XFER) begin
      cur_attr <= nxt_attr;
      cur_addr <= req_addr;
    end
  end

  bus_decode #(
    .AW(AW), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)
  ) u_decode (
    .attr(cur_attr), .addr(cur_addr), .dbg(dbg_q),
    .ext(ext), .ext_rd(ext_rd), .ext_wr(ext_wr), .int_rd(int_rd)
  );

  bus_strobes #(.AW(AW)) u_strobes (
    .clk(clk), .rst(rst), .ph(ph), .dbg(dbg_q),
    .nxt_attr(nxt_attr), .nxt_addr(req_addr),
    .cur_attr(cur_attr), .cur_addr(cur_addr),
    .ext(ext), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .addr_o(bus_addr), .fs_o(bus_fs), .ce_n(bus_ce_n),
    .we_n(bus_we_n), .rd_n(bus_rd_n), .oe(db_oe)
  );

  bus_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .ph(ph),
    .nxt_attr(nxt_attr), .cur_attr(cur_attr),
    .nxt_wdata(req_wdata), .int_rdata(int_rdata), .db_in(db_in),
    .ext_rd(ext_rd), .int_rd(int_rd),
    .db_out(db_out), .rd_data(rd_data), .rd_vld(rd_vld)
  );
endmodule

// File: rtl/bus_if_chk.sv
module bus_if_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          dbg,
  input logic          take,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ce_n,
  input logic          bus_we_n,
  input logic          bus_rd_n,
  input logic          db_oe,
  input logic          rd_vld
);
  // R4
  ce_xfer_only_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ce_n |-> take);
  // R5
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> !bus_ce_n);
  // R9
  setup_released_chk: assert property (@(posedge clk) disable iff (rst)
    !take |-> !db_oe);
  // R9
  ext_read_released_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && bus_we_n) |-> !db_oe);
  // R6
  normal_rd_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbg && !bus_rd_n) |-> !bus_ce_n);
  // R7
  debug_rd_full_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg && take) |-> $stable(bus_rd_n));
  // R2
  normal_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbg && !take) |-> $stable(bus_addr));
  // R3
  debug_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg && take) |-> $stable(bus_addr));
  // R11
  rd_vld_setup_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> !take);
endmodule

bind dualtime_bus_if bus_if_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .dbg(dbg_q), .take(take), .bus_addr(bus_addr),
  .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_rd_n(bus_rd_n),
  .db_oe(db_oe), .rd_vld(rd_vld)
);

// File: tb/test_dualtime_bus_if.sv
`timescale 1ns/1ps
module test_dualtime_bus_if;
  logic        clk = 1'b0;
  logic        rst, mode_dbg, take;
  logic        req_vld, req_wr, req_fetch, req_int;
  logic [12:0] req_addr, bus_addr;
  logic [7:0]  req_wdata, int_rdata, db_out, db_in, rd_data;
  logic        bus_fs, bus_ce_n, bus_we_n, bus_rd_n, db_oe, rd_vld;

  int n_vec = 0, n_bad = 0;
  logic        mode_q, prev_erd, pfs;
  logic [12:0] paddr;
  logic [7:0]  pdb, prev_dbi;

  always #2 clk = ~clk;

  dualtime_bus_if i_dualtime_bus_if (
    .clk(clk), .rst(rst), .mode_dbg(mode_dbg), .take(take),
    .req_vld(req_vld), .req_wr(req_wr), .req_fetch(req_fetch), .req_int(req_int),
    .req_addr(req_addr), .req_wdata(req_wdata), .int_rdata(int_rdata),
    .bus_addr(bus_addr), .bus_fs(bus_fs), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_rd_n(bus_rd_n), .db_oe(db_oe), .db_out(db_out), .db_in(db_in),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic logic in_gap(input logic [12:0] a);
    return (a >= 13'h020) && (a <= 13'h02F);
  endfunction
  function automatic logic in_ram(input logic [12:0] a);
    return (a >= 13'h040) && (a <= 13'h0FF);
  endfunction

  task automatic do_reset(input logic m);
    rst = 1'b1; mode_dbg = m; mode_q = m;
    req_vld = 0; req_wr = 0; req_fetch = 0; req_int = 0;
    req_addr = '0; req_wdata = '0; int_rdata = '0; db_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "addr rst", bus_addr, 0);
    chk("R1", "fs rst", bus_fs, 0);
    chk("R1", "ce_n rst", bus_ce_n, 1);
    chk("R1", "we_n rst", bus_we_n, 1);
    chk("R1", "rd_n rst", bus_rd_n, 1);
    chk("R1", "oe rst", db_oe, 0);
    chk("R1", "db_out rst", db_out, 0);
    chk("R1", "rd_vld rst", rd_vld, 0);
    chk("R1", "take rst", take, 0);
    rst = 1'b0;
    mode_dbg = ~m;  // R1: must be ignored after reset
    @(posedge clk); @(negedge clk);
    chk("R12", "take idle xfer", take, 1);
    chk("R4", "ce_n idle", bus_ce_n, 1);
    chk("R9", "oe idle xfer", db_oe, 1);
    paddr = '0; pfs = 1'b0; pdb = '0; prev_erd = 1'b0; prev_dbi = '0;
  endtask

  task automatic run_cycle(input logic v, input logic w, input logic f, input logic ii,
                           input logic [12:0] a, input logic [7:0] wd,
                           input logic [7:0] ird, input logic [7:0] dbi);
    logic e, erd, r8;
    e   = v && !in_gap(a) && (!ii || (mode_q && in_ram(a)));
    erd = e && !w;
    r8  = v && ii && in_ram(a) && !in_gap(a);
    req_vld = v; req_wr = w; req_fetch = f; req_int = ii; req_addr = a; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    // setup clock
    chk("R12", "take setup", take, 0);
    chk("R4", "ce_n setup", bus_ce_n, 1);
    chk("R5", "we_n setup", bus_we_n, 1);
    chk("R9", "oe setup", db_oe, 0);
    chk("R11", "rd_vld", rd_vld, prev_erd);
    if (prev_erd) chk("R11", "rd_data", rd_data, prev_dbi);
    if (mode_q) begin
      chk("R3", "addr setup", bus_addr, v ? a : paddr);
      chk("R3", "fs setup", bus_fs, v && f);
      chk("R7", "rd_n setup", bus_rd_n, !(v && !w));
    end else begin
      chk("R2", "addr setup", bus_addr, paddr);
      chk("R2", "fs setup", bus_fs, pfs);
      chk("R6", "rd_n setup", bus_rd_n, 1);
    end
    int_rdata = ird;
    @(posedge clk); @(negedge clk);
    // transfer clock
    if (v) paddr = a;
    pfs = v && f;
    if (v && w) pdb = wd;
    else if (v && !w && !e) pdb = ird;
    chk("R12", "take xfer", take, 1);
    chk(mode_q ? "R3" : "R2", "addr xfer", bus_addr, paddr);
    chk(mode_q ? "R3" : "R2", "fs xfer", bus_fs, pfs);
    chk(r8 ? "R8" : "R4", "ce_n xfer", bus_ce_n, !e);
    chk("R5", "we_n xfer", bus_we_n, !(e && w));
    if (mode_q) chk("R7", "rd_n xfer", bus_rd_n, !(v && !w));
    else        chk("R6", "rd_n xfer", bus_rd_n, !erd);
    chk("R9", "oe xfer", db_oe, !erd);
    chk("R10", "db_out xfer", db_out, pdb);
    db_in = dbi; prev_erd = erd; prev_dbi = dbi;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] al [10];
    al = '{13'h000, 13'h01F, 13'h020, 13'h02F, 13'h030,
           13'h03F, 13'h040, 13'h0FF, 13'h100, 13'h1FFF};
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int i = 0; i < 10; i++) begin
        for (int ii = 0; ii < 2; ii++) begin
          for (int w = 0; w < 2; w++) begin
            run_cycle(1'b1, w[0], al[i][0] ^ w[0], ii[0], al[i],
                      al[i][7:0] ^ 8'h5A, al[i][7:0] + 8'h33 + 8'(ii),
                      ~al[i][7:0] ^ 8'(w));
          end
        end
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 13'h0AAA, 8'hEE, 8'h11, 8'h22);
      end
      run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 13'h0000, 8'h00, 8'h00, 8'h00);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule